// File: doc/BRIEF.md
# Transmit Word-to-Bit Unpacker

This block sits between a host-side buffer reader and a MAC transmitter. A frame opens with a one-cycle start pulse that carries the frame's length in bytes. The reader then hands over the frame contents one transfer at a time through a valid/ready handshake. The block turns each transfer into bytes in buffer order, and then turns each byte into a serial stream of one bit per clock, least significant bit first. A valid flag marks every bit, and an end-of-frame flag marks the final bit.

Two configuration inputs select how a transfer is packed. In byte mode each transfer carries one byte on `in_data[7:0]`. In word mode each transfer carries two bytes, and a lane-order input selects which lane holds the even-numbered (earlier) byte. Low lane first suits little-endian hosts, and high lane first suits big-endian hosts. Because the bytes come out in buffer order, a frame laid out in the buffer as destination address, source address, type/length and payload goes out in that same order in every mode. Preamble, CRC and buffer address generation belong to other blocks.

Top module: `tx_unpacker`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `out_eof` and `busy` are all 0.
- R2: A `start` pulse while idle with a nonzero `frame_len` sets `busy` at the next clock edge. A `start` with `frame_len` of 0 is ignored and leaves `busy` and `in_ready` at 0. `out_valid` is never 1 while `busy` is 0.
- R3: With `cfg_word`=0, each transfer supplies one byte from `in_data[7:0]` and `in_data[15:8]` is ignored. Bytes are sent in transfer order.
- R4: With `cfg_word`=1 and `cfg_hi_first`=0, `in_data[7:0]` is the earlier byte and is sent before `in_data[15:8]`.
- R5: With `cfg_word`=1 and `cfg_hi_first`=1, `in_data[15:8]` is the earlier byte and is sent before `in_data[7:0]`.
- R6: Each byte is sent on 8 consecutive `out_valid` cycles, bit 0 first and bit 7 last.
- R7: In word mode with an odd `frame_len`, the final transfer supplies only its earlier lane. The other lane is dropped, so exactly `frame_len` bytes are sent.
- R8: `in_ready` is 0 while a transfer is held for serialization. At most one transfer is held at a time.
- R9: `out_eof` is 1 exactly once per frame, together with the last bit of the last byte.
- R10: `cfg_word` and `cfg_hi_first` are sampled with the accepted `start`. Changing them, or pulsing `start` again, before the frame ends has no effect on the frame.
- R11: A frame sends exactly 8×`frame_len` valid bits, and `busy` returns to 0 on the edge after the `out_eof` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse, taken only while idle |
| frame_len | input | 11 | Frame length in bytes, sampled with `start` |
| cfg_word | input | 1 | 1 = two bytes per transfer, 0 = one byte |
| cfg_hi_first | input | 1 | In word mode, 1 = high lane holds the earlier byte |
| in_valid | input | 1 | Transfer data valid |
| in_ready | output | 1 | Block can accept a transfer |
| in_data | input | 16 | Transfer data |
| out_bit | output | 1 | Serial bit |
| out_valid | output | 1 | `out_bit` is valid |
| out_eof | output | 1 | Marks the last bit of the frame |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that the reader never presents more transfers than the byte count implies and that `in_valid` only matters when `in_ready` is high. Under those assumptions the fetch count can never run ahead of the send count, and a load can only land in an empty holding register. The directed stimulus meets these assumptions by computing the exact number of transfers from the length and mode, and by driving each transfer until it sees `in_ready` at a falling edge. Mode changes and extra start pulses happen only mid-frame or after the frame, so the sampled-mode rule is exercised without leaving the handshake's assumptions.

// File: rtl/tx_unpacker_pkg.sv
package tx_unpacker_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } frame_state_e;

  typedef struct packed {
    logic word;
    logic hi_first;
  } pack_mode_t;

endpackage

// File: rtl/txu_frame_ctl.sv
module txu_frame_ctl
  import tx_unpacker_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int LANES = 2,
  localparam int LC_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             cfg_word,
  input  logic             cfg_hi_first,
  input  logic             accept,
  input  logic             byte_done,
  output logic             active,
  output pack_mode_t       mode,
  output logic [LC_W-1:0]  take_lanes,
  output logic             fetch_pending,
  output logic             last_byte
);

  frame_state_e     state_q, state_d;
  pack_mode_t       mode_q, mode_d;
  logic [LEN_W-1:0] fetch_left_q, fetch_left_d;
  logic [LEN_W-1:0] send_left_q, send_left_d;
  logic             go;

  assign go = (state_q == FS_IDLE) && start && (frame_len != '0);

  // Lanes consumed by the next transfer: one in byte mode, otherwise
  // as many as remain up to a full word.
  always_comb begin
    if (!mode_q.word) begin
      take_lanes = LC_W'(1);
    end else if (fetch_left_q >= LEN_W'(LANES)) begin
      take_lanes = LC_W'(LANES);
    end else begin
      take_lanes = fetch_left_q[LC_W-1:0];
    end
  end

  always_comb begin
    state_d      = state_q;
    mode_d       = mode_q;
    fetch_left_d = fetch_left_q;
    send_left_d  = send_left_q;
    if (go) begin
      state_d      = FS_RUN;
      mode_d.word     = cfg_word;
      mode_d.hi_first = cfg_hi_first;
      fetch_left_d = frame_len;
      send_left_d  = frame_len;
    end else if (state_q == FS_RUN) begin
      if (accept) begin
        fetch_left_d = fetch_left_q - LEN_W'(take_lanes);
      end
      if (byte_done) begin
        send_left_d = send_left_q - LEN_W'(1);
        if (send_left_q == LEN_W'(1)) begin
          state_d = FS_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= FS_IDLE;
      mode_q       <= '0;
      fetch_left_q <= '0;
      send_left_q  <= '0;
    end else begin
      state_q      <= state_d;
      mode_q       <= mode_d;
      fetch_left_q <= fetch_left_d;
      send_left_q  <= send_left_d;
    end
  end

  assign active        = (state_q == FS_RUN);
  assign mode          = mode_q;
  assign fetch_pending = active && (fetch_left_q != '0);
  assign last_byte     = active && (send_left_q == LEN_W'(1));

  // R11
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_left_q <= send_left_q);

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (active && send_left_q != '0));

endmodule

// File: rtl/txu_lane_hold.sv
module txu_lane_hold
  import tx_unpacker_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int LI_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LC_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [LC_W-1:0]   load_lanes,
  input  pack_mode_t        mode,
  input  logic              byte_done,
  output logic              held,
  output logic [BYTE_W-1:0] cur_byte
);

  logic [DATA_W-1:0] word_q, word_d;
  logic              held_q, held_d;
  logic [LC_W-1:0]   lanes_q, lanes_d;
  logic [LI_W-1:0]   idx_q, idx_d;
  logic [LI_W-1:0]   phys;
  logic [BYTE_W-1:0] lane_b [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_b[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  // Logical position to physical lane; byte mode always uses lane 0.
  always_comb begin
    if (!mode.word) begin
      phys = '0;
    end else if (mode.hi_first) begin
      phys = LI_W'(LANES - 1) - idx_q;
    end else begin
      phys = idx_q;
    end
  end

  assign cur_byte = lane_b[phys];

  always_comb begin
    word_d  = word_q;
    held_d  = held_q;
    lanes_d = lanes_q;
    idx_d   = idx_q;
    if (load) begin
      word_d  = load_data;
      held_d  = 1'b1;
      lanes_d = load_lanes;
      idx_d   = '0;
    end else if (held_q && byte_done) begin
      if (LC_W'(idx_q) + LC_W'(1) >= lanes_q) begin
        held_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + LI_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      lanes_q <= '0;
      idx_q   <= '0;
    end else begin
      held_q  <= held_d;
      lanes_q <= lanes_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= word_d;
    end
  end

  assign held = held_q;

  // R8
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !held_q);

endmodule

// File: rtl/txu_bit_ser.sv
module txu_bit_ser #(
  parameter int BYTE_W = 8,
  localparam int BI_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              held,
  input  logic [BYTE_W-1:0] cur_byte,
  output logic              ser_bit,
  output logic              byte_done
);

  logic [BI_W-1:0] bit_q, bit_d;

  assign byte_done = held && (bit_q == BI_W'(BYTE_W - 1));
  assign ser_bit   = cur_byte[bit_q];

  always_comb begin
    bit_d = bit_q;
    if (held) begin
      bit_d = byte_done ? '0 : bit_q + BI_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else begin
      bit_q <= bit_d;
    end
  end

  // R6
  byte_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !byte_done) |=> held);

endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker
  import tx_unpacker_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 11,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int LC_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              cfg_word,
  input  logic              cfg_hi_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_bit,
  output logic              out_valid,
  output logic              out_eof,
  output logic              busy
);

  logic              active;
  pack_mode_t        mode;
  logic [LC_W-1:0]   take_lanes;
  logic              fetch_pending;
  logic              last_byte;
  logic              accept;
  logic              held;
  logic              byte_done;
  logic [BYTE_W-1:0] cur_byte;

  assign in_ready = fetch_pending && !held;
  assign accept   = in_valid && in_ready;

  txu_frame_ctl #(.LEN_W(LEN_W), .LANES(LANES)) i_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .cfg_word(cfg_word), .cfg_hi_first(cfg_hi_first), .accept(accept),
    .byte_done(byte_done), .active(active), .mode(mode),
    .take_lanes(take_lanes), .fetch_pending(fetch_pending),
    .last_byte(last_byte)
  );

  txu_lane_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(in_data),
    .load_lanes(take_lanes), .mode(mode), .byte_done(byte_done),
    .held(held), .cur_byte(cur_byte)
  );

  txu_bit_ser #(.BYTE_W(BYTE_W)) i_ser (
    .clk(clk), .rst_n(rst_n), .held(held), .cur_byte(cur_byte),
    .ser_bit(out_bit), .byte_done(byte_done)
  );

  assign out_valid = held;
  assign out_eof   = byte_done && last_byte;
  assign busy      = active;

  // R9
  eof_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !busy);

  // R2
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

endmodule

// File: tb/test_tx_unpacker.sv
module test_tx_unpacker;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [10:0] frame_len;
  logic        cfg_word;
  logic        cfg_hi_first;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        out_bit;
  logic        out_valid;
  logic        out_eof;
  logic        busy;

  int errors = 0;
  int checks = 0;

  logic [7:0] tx_b [64];
  logic [7:0] rx_b [64];
  int         rx_cnt;
  int         bit_tot;
  int         eof_cnt;
  int         eof_at;
  int         gap_err;
  int         ready_err;
  int         bpos;
  logic [7:0] acc;

  tx_unpacker i_tx_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .cfg_word(cfg_word), .cfg_hi_first(cfg_hi_first), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_bit(out_bit),
    .out_valid(out_valid), .out_eof(out_eof), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Serial collector, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready && out_valid) ready_err++;
      if (out_valid) begin
        acc[bpos] = out_bit;
        bit_tot++;
        if (out_eof) begin
          eof_cnt++;
          eof_at = bit_tot;
        end
        if (bpos == 7) begin
          if (rx_cnt < 64) rx_b[rx_cnt] = acc;
          rx_cnt++;
          bpos = 0;
        end else begin
          bpos++;
        end
      end else begin
        if (bpos != 0) gap_err++;
        if (out_eof) eof_cnt++;
      end
    end
  end

  task automatic clear_mon();
    rx_cnt = 0; bit_tot = 0; eof_cnt = 0; eof_at = -1;
    gap_err = 0; ready_err = 0; bpos = 0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < 64; i++) tx_b[i] = 8'((i * 37 + seed) & 8'hff);
  endtask

  // Runs a whole frame; optionally disturbs mode and start mid-frame.
  task automatic run_frame(input int n, input bit w, input bit hi,
                           input bit disturb, input string req);
    int xfers;
    int mism;
    int first_bad;
    clear_mon();
    @(posedge clk); #1;
    start = 1'b1; frame_len = 11'(n); cfg_word = w; cfg_hi_first = hi;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    xfers = w ? (n + 1) / 2 : n;
    for (int t = 0; t < xfers; t++) begin
      logic [7:0] e0, e1;
      e0 = tx_b[w ? 2*t : t];
      e1 = (w && (2*t + 1 < n)) ? tx_b[2*t + 1] : 8'h3c;
      if (!w)      in_data = {8'ha5, e0};
      else if (hi) in_data = {e0, e1};
      else         in_data = {e1, e0};
      in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (disturb && t == 0) begin
        cfg_word = ~w; cfg_hi_first = ~hi;
        start = 1'b1; frame_len = 11'd3;
        @(posedge clk); #1;
        start = 1'b0;
      end
    end
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
    mism = 0; first_bad = -1;
    for (int i = 0; i < n && i < 64; i++) begin
      if (i >= rx_cnt || rx_b[i] !== tx_b[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    check(mism == 0, req, "byte order mismatches", mism, 0);
    if (first_bad >= 0)
      $display("  first bad byte %0d got %h want %h", first_bad,
               rx_b[first_bad], tx_b[first_bad]);
    check(bit_tot == 8 * n, "R11", "valid bit count", bit_tot, 8 * n);
    check(eof_cnt == 1 && eof_at == 8 * n, "R9", "eof position", eof_at, 8 * n);
    check(gap_err == 0, "R6", "gaps inside a byte", gap_err, 0);
    check(ready_err == 0, "R8", "ready while holding", ready_err, 0);
    check(busy == 1'b0 && in_ready == 1'b0, "R11", "idle after frame",
          int'(busy), 0);
  endtask

  task automatic t_reset();
    check(!in_ready && !out_valid && !out_eof && !busy, "R1", "reset outputs",
          int'({in_ready, out_valid, out_eof, busy}), 0);
  endtask

  task automatic t_zero_len();
    @(posedge clk); #1;
    start = 1'b1; frame_len = 11'd0;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !in_ready && !out_valid, "R2", "zero length ignored",
          int'({busy, in_ready, out_valid}), 0);
  endtask

  task automatic t_byte_mode();   // R3: upper lane carries 8'ha5 filler
    fill(14, 3);
    run_frame(14, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_word_lo();     // R4, R6 LSB-first compare
    fill(20, 91);
    run_frame(20, 1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_word_hi();     // R5
    fill(18, 200);
    run_frame(18, 1'b1, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_odd_len();     // R7: dropped lane holds 8'h3c
    fill(15, 17);
    run_frame(15, 1'b1, 1'b0, 1'b0, "R7");
    fill(1, 66);
    run_frame(1, 1'b1, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_mode_hold();   // R10
    fill(10, 123);
    run_frame(10, 1'b1, 1'b1, 1'b1, "R10");
    fill(6, 9);
    run_frame(6, 1'b0, 1'b0, 1'b1, "R10");
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; frame_len = '0; cfg_word = 1'b0;
    cfg_hi_first = 1'b0; in_valid = 1'b0; in_data = '0;
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_byte_mode();
    t_word_lo();
    t_word_hi();
    t_odd_len();
    t_mode_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule